// File: doc/BRIEF.md
# Nibble-Serial Ethernet Frame Check Sequence Checker

This block verifies the 32-bit frame check sequence of an Ethernet frame that arrives four bits at a time. A receive controller pulses a start input at the beginning of each frame. It then presents, with a valid strobe, every nibble that follows the start-of-frame delimiter, up to and including the four FCS bytes. Preamble and delimiter nibbles are never presented. The checker keeps a 32-bit remainder register that absorbs one nibble on each valid cycle and holds its value on all other cycles.

On the receive interface, the least significant bit of each nibble is the first bit on the wire. The block reverses the nibble before it reaches the CRC logic, so that the remainder can be computed most-significant-bit first with the plain generator polynomial. A correct frame leaves the remainder at a fixed residue, and the error output is low exactly while the remainder holds that residue. The controller samples the error flag once the last FCS nibble has been absorbed.

Top module: `crc_nib_checker`

## Requirements
- R1: While reset is asserted, and in the cycle after it, the error output is high and the remainder holds the all-ones preset.
- R2: A start pulse with valid low presets the remainder to all ones on that clock edge and drives the error output high. This discards any partial frame.
- R3: Each received nibble is reversed before it enters the CRC logic: receive bit 0 feeds CRC input bit 3, bit 1 feeds bit 2, bit 2 feeds bit 1, and bit 3 feeds bit 0. CRC input bit 3 is shifted in first.
- R4: The remainder is computed most-significant-bit first with generator 0x04C11DB7, from an all-ones preset, with no output inversion. The nine ASCII bytes "123456789", followed by their FCS, form a passing frame.
- R5: A frame passes when it consists of payload bytes followed by their standard Ethernet FCS. The FCS is the complemented reflected CRC-32, sent least significant byte first. Every byte is sent low nibble first. The error output is low in the cycle after the last FCS nibble is absorbed.
- R6: A frame in which any single bit of the payload or the FCS is flipped leaves the error output high.
- R7: On cycles with valid low and start low, the remainder and the error output hold. Idle gaps anywhere inside a frame do not change the outcome.
- R8: A start pulse that coincides with valid absorbs that nibble as the first nibble of a new frame, starting from the preset.
- R9: The error output is low exactly when the remainder equals 0xC704DD7B. A further nibble absorbed after a passing frame raises the error output again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Presets the remainder at the start of a frame |
| nib_valid | input | 1 | The nibble on `rxd` is absorbed this cycle |
| rxd | input | 4 | Receive nibble; bit 0 is the first bit on the wire |
| crc_err | output | 1 | High unless the remainder equals the good-frame residue |

## Verification
The bench builds the checker with its default parameters: a 32-bit remainder, 4-bit nibbles, input reversal enabled, and the Ethernet generator, preset and residue. With these values, frames whose FCS the bench computes with an independent byte-wise reflected CRC-32 can be fed straight in. This covers the reordering and the polynomial together. It also covers idle gaps, restarts in the middle of a frame, a start that coincides with valid, and single-bit corruption in both the payload and the FCS.

// File: rtl/crc_chk_pkg.sv
package crc_chk_pkg;

    localparam int unsigned CRC_W          = 32;
    localparam int unsigned NIB_W          = 4;
    localparam logic [CRC_W-1:0] GEN_POLY  = 32'h04C1_1DB7;
    localparam logic [CRC_W-1:0] PRESET    = 32'hFFFF_FFFF;
    localparam logic [CRC_W-1:0] GOOD_RES  = 32'hC704_DD7B;

    // Action applied to the remainder register on a clock edge
    typedef enum logic [1:0] {
        CMD_HOLD      = 2'd0,
        CMD_STEP      = 2'd1,
        CMD_LOAD      = 2'd2,
        CMD_LOAD_STEP = 2'd3
    } crc_cmd_e;

    // Chooses the register's next action from the control inputs
    function automatic crc_cmd_e decode_cmd(input logic start, input logic valid);
        crc_cmd_e c;
        unique case ({start, valid})
            2'b00:   c = CMD_HOLD;
            2'b01:   c = CMD_STEP;
            2'b10:   c = CMD_LOAD;
            default: c = CMD_LOAD_STEP;
        endcase
        return c;
    endfunction

    // One most-significant-bit-first shift of a remainder by a single input bit
    function automatic logic [CRC_W-1:0] crc_bit_shift(
        input logic [CRC_W-1:0] cur,
        input logic             din,
        input logic [CRC_W-1:0] poly
    );
        logic fb;
        fb = cur[CRC_W-1] ^ din;
        return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
    endfunction

endpackage

// File: rtl/crc_nib_reorder.sv
module crc_nib_reorder #(
    parameter int unsigned NIB_W   = crc_chk_pkg::NIB_W,
    parameter bit          REVERSE = 1'b1
) (
    input  logic [NIB_W-1:0] nib_in,
    output logic [NIB_W-1:0] nib_out
);

    generate
        if (REVERSE) begin : g_rev
            // The first wire bit ends up in the top position, which is shifted in first
            for (genvar i = 0; i < NIB_W; i++) begin : g_bit
                assign nib_out[i] = nib_in[NIB_W-1-i];
            end
        end else begin : g_pass
            assign nib_out = nib_in;
        end
    endgenerate

endmodule

// File: rtl/crc_nib_step.sv
module crc_nib_step #(
    parameter int unsigned     CRC_W = crc_chk_pkg::CRC_W,
    parameter int unsigned     NIB_W = crc_chk_pkg::NIB_W,
    parameter logic [CRC_W-1:0] POLY = crc_chk_pkg::GEN_POLY
) (
    input  logic [CRC_W-1:0] cur,
    input  logic [NIB_W-1:0] din,
    output logic [CRC_W-1:0] nxt
);
    import crc_chk_pkg::*;

    // chain[0] is the incoming remainder; chain[k] follows k shifted bits
    logic [CRC_W-1:0] chain [0:NIB_W];

    assign chain[0] = cur;

    generate
        for (genvar k = 0; k < NIB_W; k++) begin : g_stage
            // The highest input bit is consumed first
            assign chain[k+1] = crc_bit_shift(chain[k], din[NIB_W-1-k], POLY);
        end
    endgenerate

    assign nxt = chain[NIB_W];

endmodule

// File: rtl/crc_state_reg.sv
module crc_state_reg #(
    parameter int unsigned      CRC_W  = crc_chk_pkg::CRC_W,
    parameter logic [CRC_W-1:0] INIT   = crc_chk_pkg::PRESET
) (
    input  logic             clk,
    input  logic             rst,
    input  crc_chk_pkg::crc_cmd_e cmd,
    input  logic [CRC_W-1:0] stepped_cur,
    input  logic [CRC_W-1:0] stepped_init,
    output logic [CRC_W-1:0] state
);
    import crc_chk_pkg::*;

    logic [CRC_W-1:0] state_d;

    always_comb begin
        unique case (cmd)
            CMD_STEP:      state_d = stepped_cur;
            CMD_LOAD:      state_d = INIT;
            CMD_LOAD_STEP: state_d = stepped_init;
            default:       state_d = state;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= INIT;
        else     state <= state_d;
    end

    // R2
    preset_on_start_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_LOAD) |=> (state == INIT));

    // R7
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd == CMD_HOLD) |=> $stable(state));

endmodule

// File: rtl/crc_nib_checker.sv
module crc_nib_checker #(
    parameter int unsigned      CRC_W   = crc_chk_pkg::CRC_W,
    parameter int unsigned      NIB_W   = crc_chk_pkg::NIB_W,
    parameter logic [CRC_W-1:0] POLY    = crc_chk_pkg::GEN_POLY,
    parameter logic [CRC_W-1:0] INIT    = crc_chk_pkg::PRESET,
    parameter logic [CRC_W-1:0] RESIDUE = crc_chk_pkg::GOOD_RES,
    parameter bit               REVERSE = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             frame_start,
    input  logic             nib_valid,
    input  logic [NIB_W-1:0] rxd,
    output logic             crc_err
);
    import crc_chk_pkg::*;

    logic [NIB_W-1:0] crc_in;
    logic [CRC_W-1:0] rem_q;
    logic [CRC_W-1:0] nxt_from_rem;
    logic [CRC_W-1:0] nxt_from_init;
    crc_cmd_e         cmd;

    assign cmd = decode_cmd(frame_start, nib_valid);

    crc_nib_reorder #(
        .NIB_W   (NIB_W),
        .REVERSE (REVERSE)
    ) u_reorder (
        .nib_in  (rxd),
        .nib_out (crc_in)
    );

    // Step from the live remainder: normal absorption
    crc_nib_step #(
        .CRC_W (CRC_W),
        .NIB_W (NIB_W),
        .POLY  (POLY)
    ) u_step_run (
        .cur (rem_q),
        .din (crc_in),
        .nxt (nxt_from_rem)
    );

    // Step from the preset: a start that coincides with valid
    crc_nib_step #(
        .CRC_W (CRC_W),
        .NIB_W (NIB_W),
        .POLY  (POLY)
    ) u_step_first (
        .cur (INIT),
        .din (crc_in),
        .nxt (nxt_from_init)
    );

    crc_state_reg #(
        .CRC_W (CRC_W),
        .INIT  (INIT)
    ) u_state (
        .clk          (clk),
        .rst          (rst),
        .cmd          (cmd),
        .stepped_cur  (nxt_from_rem),
        .stepped_init (nxt_from_init),
        .state        (rem_q)
    );

    assign crc_err = (rem_q != RESIDUE);

    // R1
    err_after_reset_chk: assert property (@(posedge clk)
        rst |=> crc_err);

    // R9
    pass_needs_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(crc_err) |-> $past(nib_valid));

    // R8
    start_valid_absorbs_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_start && nib_valid) |=> (rem_q != INIT) || (nxt_from_init == INIT));

endmodule

// File: tb/crc_nib_checker_tb.sv
module crc_nib_checker_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       frame_start = 1'b0;
    logic       nib_valid = 1'b0;
    logic [3:0] rxd = 4'h0;
    logic       crc_err;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [7:0] frm [0:255];
    int         flen;

    always #5 clk = ~clk;

    crc_nib_checker u_dut (
        .clk         (clk),
        .rst         (rst),
        .frame_start (frame_start),
        .nib_valid   (nib_valid),
        .rxd         (rxd),
        .crc_err     (crc_err)
    );

    task automatic chk(input bit ok, input string req, input logic act, input logic exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: crc_err actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // Byte-wise reflected CRC-32 over frm[0..n-1], complemented
    function automatic logic [31:0] ref_fcs(input int n);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int i = 0; i < n; i++) begin
            c ^= {24'h0, frm[i]};
            for (int b = 0; b < 8; b++)
                c = c[0] ? ((c >> 1) ^ 32'hEDB8_8320) : (c >> 1);
        end
        return ~c;
    endfunction

    // Appends the FCS least significant byte first; flen then covers it
    task automatic append_fcs(input int n);
        logic [31:0] f = ref_fcs(n);
        for (int k = 0; k < 4; k++) frm[n+k] = f[8*k +: 8];
        flen = n + 4;
    endtask

    task automatic fill(input int n, input int mode);
        logic [31:0] s = 32'h1234_5678;
        for (int i = 0; i < n; i++) begin
            s = s * 32'd1103515245 + 32'd12345;
            case (mode)
                0: frm[i] = 8'(i);
                1: frm[i] = 8'h00;
                2: frm[i] = 8'hFF;
                default: frm[i] = s[23:16];
            endcase
        end
        append_fcs(n);
    endtask

    task automatic pulse_start();
        @(negedge clk); frame_start = 1'b1; nib_valid = 1'b0;
        @(negedge clk); frame_start = 1'b0;
    endtask

    // Sends bytes [from, to) low nibble first; gaps add idle cycles; first_with_start merges start
    task automatic send(input int from, input int to, input bit gaps, input bit first_with_start);
        int cnt = 0;
        for (int i = from; i < to; i++) begin
            for (int h = 0; h < 2; h++) begin
                @(negedge clk);
                frame_start = first_with_start && (cnt == 0);
                nib_valid = 1'b1;
                rxd = h == 0 ? frm[i][3:0] : frm[i][7:4];
                cnt++;
                if (gaps && (cnt % 3 == 0)) begin
                    @(negedge clk);
                    frame_start = 1'b0; nib_valid = 1'b0; rxd = 4'hA;
                end
            end
        end
        @(negedge clk);
        frame_start = 1'b0; nib_valid = 1'b0; rxd = 4'h5;
    endtask

    task automatic t_reset();
        chk(crc_err === 1'b1, "R1 during reset", crc_err, 1'b1);
        @(negedge clk); rst = 1'b0;
        chk(crc_err === 1'b1, "R1 after reset", crc_err, 1'b1);
    endtask

    task automatic t_known_vector();
        string s = "123456789";
        for (int i = 0; i < 9; i++) frm[i] = s[i];
        chk(ref_fcs(9) == 32'hCBF4_3926, "R4 bench reference", 1'b0, 1'b0);
        append_fcs(9);
        pulse_start();
        send(0, flen, 1'b0, 1'b0);
        chk(crc_err === 1'b0, "R4 known vector R3 order", crc_err, 1'b0);
    endtask

    task automatic t_good(input int n, input int mode);
        fill(n, mode);
        pulse_start();
        chk(crc_err === 1'b1, "R2 start raises error", crc_err, 1'b1);
        send(0, n / 2, 1'b0, 1'b0);
        chk(crc_err === 1'b1, "R9 mid-frame high", crc_err, 1'b1);
        send(n / 2, flen, 1'b0, 1'b0);
        chk(crc_err === 1'b0, "R5 good frame passes", crc_err, 1'b0);
    endtask

    task automatic t_gaps();
        fill(40, 3);
        pulse_start();
        send(0, flen, 1'b1, 1'b0);
        chk(crc_err === 1'b0, "R7 gapped frame passes", crc_err, 1'b0);
        repeat (5) @(negedge clk);
        chk(crc_err === 1'b0, "R7 idle keeps pass", crc_err, 1'b0);
    endtask

    task automatic t_bad(input int pos, input int bitn);
        fill(30, 0);
        frm[pos][bitn] = ~frm[pos][bitn];
        pulse_start();
        send(0, flen, 1'b0, 1'b0);
        chk(crc_err === 1'b1, "R6 corrupted frame fails", crc_err, 1'b1);
    endtask

    task automatic t_restart();
        fill(20, 3);
        pulse_start();
        send(0, 7, 1'b0, 1'b0);
        fill(24, 0);
        pulse_start();
        chk(crc_err === 1'b1, "R2 restart raises error", crc_err, 1'b1);
        send(0, flen, 1'b0, 1'b0);
        chk(crc_err === 1'b0, "R2 restarted frame passes", crc_err, 1'b0);
    endtask

    task automatic t_merged_start();
        fill(16, 3);
        pulse_start();
        send(0, 5, 1'b0, 1'b0);
        send(0, flen, 1'b0, 1'b1);
        chk(crc_err === 1'b0, "R8 start with valid passes", crc_err, 1'b0);
    endtask

    task automatic t_extra_nibble();
        fill(12, 2);
        pulse_start();
        send(0, flen, 1'b0, 1'b0);
        chk(crc_err === 1'b0, "R9 pass before extra", crc_err, 1'b0);
        @(negedge clk); nib_valid = 1'b1; rxd = 4'h3;
        @(negedge clk); nib_valid = 1'b0;
        chk(crc_err === 1'b1, "R9 extra nibble raises", crc_err, 1'b1);
    endtask

    initial begin : watchdog
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog: actual=timeout expected=done");
                $display("Simulation finished: %0d checks, %0d errors", checks, errors);
                $finish;
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_known_vector();
        t_good(46, 0);
        t_good(60, 1);
        t_good(64, 3);
        t_good(10, 2);
        t_gaps();
        t_bad(3, 0);
        t_bad(17, 7);
        t_bad(31, 4);
        t_bad(33, 1);
        t_restart();
        t_merged_start();
        t_extra_nibble();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule